// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt

This block is the hardwired control unit of a small accumulator machine. It holds the program counter, the memory address and memory buffer registers, the instruction register and the accumulator. It moves through fetch, indirect, execute and interrupt cycles, one micro-operation group per clock. Every memory access goes through a single-port synchronous memory. The memory address always comes from the address register, and write data always comes from the buffer register. Read data returns one cycle after the read strobe.

The machine has four instructions: accumulate from memory, bump-and-skip-if-zero, enable interrupts, and halt. Accumulate and bump-and-skip can each be direct or indirect. When an execute cycle ends, the sequencer tests the request line against its enable flag. If both are set, it saves the return address at a fixed location, jumps to a fixed vector and masks further interrupts. A halt instruction parks the sequencer until reset.

Top module: `instr_cycle_seq`

## Requirements
- R1: While reset is held, pc_q is 0x010, acc_q is 0, int_en_q is 0, halted is 0, and both memory strobes are low.
- R2: A fetch takes three cycles.
  - Cycle one loads the address register from the program counter.
  - Cycle two raises mem_rd and increments the program counter.
  - Cycle three captures the word into the instruction register.
  - A program of one direct accumulate followed by halt raises halted 10 cycles after its first mem_rd.
- R3: The instruction word is 16 bits: bit 15 is the indirect flag, bits [14:12] the opcode, bits [11:0] the address. Opcodes: 0 accumulate, 1 bump-and-skip, 2 enable interrupts, 7 halt; any other value does nothing.
- R4: Accumulate adds the memory word at the operand address into acc_q, modulo 2^16. acc_q changes at no other time.
- R5: With the indirect flag set, three extra cycles read the word at the address field, and its low 12 bits replace the operand address. The execute cycle always follows. A program of two accumulates, the first indirect, then halt, raises halted 20 cycles after the first mem_rd.
- R6: Bump-and-skip writes the memory word plus one back to the same address, in exactly one write. In that same step the program counter advances once more if the written value is zero, which skips the next instruction.
- R7: Enable-interrupts sets int_en_q. The end-of-execute test of that same instruction still sees the old, cleared enable.
- R8: If irq_req and the enable are both high when an execute cycle ends, the sequencer enters the interrupt cycle. It writes the program counter, zero-extended, to address 0x000. It then sets the program counter to 0x001, clears int_en_q and resumes with a fetch.
- R9: While int_en_q is 0, irq_req has no effect: no extra write and no change in flow or timing.
- R10: After a halt instruction, halted stays high, both strobes stay low and pc_q is frozen until reset.
- R11: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 1 | Interrupt request level |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_rd |
| mem_addr | output | 12 | Memory address (address register) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (buffer register) |
| acc_q | output | 16 | Accumulator |
| pc_q | output | 12 | Program counter |
| int_en_q | output | 1 | Interrupt enable flag |
| halted | output | 1 | Sequencer parked by a halt instruction |

## Verification
A wrong cycle state shows at the ports within one or two clocks. A strobe lands in the wrong phase, or a write carries the wrong address or data. The scoreboard compares each write against the write sequence derived from the program. A lost or extra state shifts the cycle count from the first read strobe to halted. A wrong skip or interrupt decision changes which instructions run, so the final accumulator, program counter and enable flag differ from the values the program implies.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int OPC_W = 3;

  typedef enum logic [3:0] {
    ST_F1, ST_F2, ST_F3,
    ST_I1, ST_I2, ST_I3,
    ST_E1, ST_E2, ST_E3, ST_E4,
    ST_T1, ST_T2,
    ST_HALT
  } seq_state_e;

  localparam logic [OPC_W-1:0] OP_ADD  = 3'd0;
  localparam logic [OPC_W-1:0] OP_BSZ  = 3'd1;
  localparam logic [OPC_W-1:0] OP_EI   = 3'd2;
  localparam logic [OPC_W-1:0] OP_HALT = 3'd7;

  // one bit per micro-operation
  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mar_save;
    logic mem_rd;
    logic mem_wr;
    logic pc_inc;
    logic pc_skipz;
    logic pc_vec;
    logic mbr_bus;
    logic mbr_inc;
    logic mbr_pc;
    logic ir_load;
    logic ir_addr;
    logic acc_add;
    logic ien_set;
    logic ien_clr;
  } uop_t;

  function automatic logic uses_operand(input logic [OPC_W-1:0] op);
    return (op == OP_ADD) || (op == OP_BSZ);
  endfunction

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ind_bit,
  input  logic [OPC_W-1:0] opcode,
  input  logic             irq_pend,
  output seq_state_e       state
);
  seq_state_e state_d;
  seq_state_e after_exec;

  always_comb begin
    after_exec = irq_pend ? ST_T1 : ST_F1;
    state_d    = state;
    unique case (state)
      ST_F1:   state_d = ST_F2;
      ST_F2:   state_d = ST_F3;
      ST_F3:   state_d = ind_bit ? ST_I1 : ST_E1;
      ST_I1:   state_d = ST_I2;
      ST_I2:   state_d = ST_I3;
      ST_I3:   state_d = ST_E1;
      ST_E1: begin
        if (opcode == OP_HALT)        state_d = ST_HALT;
        else if (uses_operand(opcode)) state_d = ST_E2;
        else                           state_d = after_exec;
      end
      ST_E2:   state_d = ST_E3;
      ST_E3:   state_d = ST_E4;
      ST_E4:   state_d = after_exec;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_F1;
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_F1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_F1;
    else        state <= state_d;
  end
endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  seq_state_e       state,
  input  logic [OPC_W-1:0] opcode,
  output uop_t             uop
);
  always_comb begin
    uop = '0;
    unique case (state)
      ST_F1: uop.mar_pc = 1'b1;
      ST_F2: begin
        uop.mem_rd = 1'b1;
        uop.pc_inc = 1'b1;
      end
      ST_F3: begin
        uop.mbr_bus = 1'b1;
        uop.ir_load = 1'b1;
      end
      ST_I1: uop.mar_ir = 1'b1;
      ST_I2: uop.mem_rd = 1'b1;
      ST_I3: begin
        uop.mbr_bus = 1'b1;
        uop.ir_addr = 1'b1;
      end
      ST_E1: begin
        uop.mar_ir  = uses_operand(opcode);
        uop.ien_set = (opcode == OP_EI);
      end
      ST_E2: uop.mem_rd = 1'b1;
      ST_E3: begin
        uop.mbr_bus = (opcode == OP_ADD);
        uop.mbr_inc = (opcode == OP_BSZ);
      end
      ST_E4: begin
        uop.acc_add  = (opcode == OP_ADD);
        uop.mem_wr   = (opcode == OP_BSZ);
        uop.pc_skipz = (opcode == OP_BSZ);
      end
      ST_T1: begin
        uop.mar_save = 1'b1;
        uop.mbr_pc   = 1'b1;
      end
      ST_T2: begin
        uop.mem_wr  = 1'b1;
        uop.pc_vec  = 1'b1;
        uop.ien_clr = 1'b1;
      end
      default: uop = '0;
    endcase
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int RESET_PC  = 16,
  parameter int SAVE_ADDR = 0,
  parameter int VEC_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  uop_t              uop,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mbr_q,
  output logic [DATA_W-1:0] ir_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] acc_q,
  output logic              ien_q
);
  localparam logic [ADDR_W-1:0] PC_RST = ADDR_W'(RESET_PC);
  localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);
  localparam logic [ADDR_W-1:0] VEC_A  = ADDR_W'(VEC_ADDR);

  logic              pc_en, mar_en, mbr_en, ir_en, acc_en, ien_en;
  logic [ADDR_W-1:0] pc_d, mar_d;
  logic [DATA_W-1:0] mbr_d, ir_d, acc_d;
  logic              ien_d, mbr_zero;

  always_comb begin
    mbr_zero = (mbr_q == '0);

    pc_en = uop.pc_vec | uop.pc_inc | (uop.pc_skipz & mbr_zero);
    pc_d  = uop.pc_vec ? VEC_A : ADDR_W'(pc_q + 1'b1);

    mar_en = uop.mar_pc | uop.mar_ir | uop.mar_save;
    if (uop.mar_pc)      mar_d = pc_q;
    else if (uop.mar_ir) mar_d = ir_q[ADDR_W-1:0];
    else                 mar_d = SAVE_A;

    mbr_en = uop.mbr_bus | uop.mbr_inc | uop.mbr_pc;
    if (uop.mbr_pc)       mbr_d = DATA_W'(pc_q);
    else if (uop.mbr_inc) mbr_d = DATA_W'(mem_rdata + 1'b1);
    else                  mbr_d = mem_rdata;

    ir_en = uop.ir_load | uop.ir_addr;
    ir_d  = uop.ir_load ? mem_rdata
                        : {ir_q[DATA_W-1:ADDR_W], mem_rdata[ADDR_W-1:0]};

    acc_en = uop.acc_add;
    acc_d  = DATA_W'(acc_q + mbr_q);

    ien_en = uop.ien_set | uop.ien_clr;
    ien_d  = uop.ien_set & ~uop.ien_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= PC_RST;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      ien_q <= 1'b0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (mar_en) mar_q <= mar_d;
      if (mbr_en) mbr_q <= mbr_d;
      if (ir_en)  ir_q  <= ir_d;
      if (acc_en) acc_q <= acc_d;
      if (ien_en) ien_q <= ien_d;
    end
  end
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import seq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int RESET_PC  = 16,
  parameter int SAVE_ADDR = 0,
  parameter int VEC_ADDR  = 1,
  localparam int DATA_W   = 1 + OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] acc_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic              int_en_q,
  output logic              halted
);
  logic              rst_core_n;
  seq_state_e        state;
  uop_t              uop;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mbr_q, ir_q;
  logic [OPC_W-1:0]  opcode;
  logic              irq_pend;

  assign opcode   = ir_q[DATA_W-2 -: OPC_W];
  assign irq_pend = irq_req & int_en_q;

  seq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ind_bit  (mem_rdata[DATA_W-1]),
    .opcode   (opcode),
    .irq_pend (irq_pend),
    .state    (state)
  );

  seq_decode u_dec (
    .state  (state),
    .opcode (opcode),
    .uop    (uop)
  );

  seq_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RESET_PC  (RESET_PC),
    .SAVE_ADDR (SAVE_ADDR),
    .VEC_ADDR  (VEC_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .uop       (uop),
    .mem_rdata (mem_rdata),
    .mar_q     (mar_q),
    .mbr_q     (mbr_q),
    .ir_q      (ir_q),
    .pc_q      (pc_q),
    .acc_q     (acc_q),
    .ien_q     (int_en_q)
  );

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign mem_rd    = uop.mem_rd;
  assign mem_wr    = uop.mem_wr;
  assign halted    = (state == ST_HALT);
endmodule

// File: rtl/seq_chk.sv
module seq_chk
  import seq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int VEC_ADDR = 1
) (
  input logic              clk,
  input logic              rst_core_n,
  input seq_state_e        state,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              halted,
  input logic [ADDR_W-1:0] pc_q,
  input logic [DATA_W-1:0] acc_q,
  input logic              int_en_q
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(mem_rd && mem_wr)); // R11
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_core_n)
    halted |=> halted); // R10
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_core_n)
    halted |-> (!mem_rd && !mem_wr)); // R10
  AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_core_n)
    halted |=> $stable(pc_q)); // R10
  AST_FETCH_PC_STEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == ST_F2) |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1))); // R2
  AST_INDIRECT_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == ST_I3) |=> (state == ST_E1)); // R5
  AST_INT_VECTOR: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == ST_T2) |=> (pc_q == ADDR_W'(VEC_ADDR) && !int_en_q && state == ST_F1)); // R8
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state != ST_E4) |=> $stable(acc_q)); // R4
endmodule

bind instr_cycle_seq seq_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .VEC_ADDR (VEC_ADDR)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .state      (state),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .halted     (halted),
  .pc_q       (pc_q),
  .acc_q      (acc_q),
  .int_en_q   (int_en_q)
);

// File: tb/tb_instr_cycle_seq.sv
module tb_instr_cycle_seq;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int MEMW = 256;

  logic          clk = 1'b0;
  logic          rst_n, irq_req;
  logic [DW-1:0] mem_rdata, mem_wdata, acc_q;
  logic [AW-1:0] mem_addr, pc_q;
  logic          mem_rd, mem_wr, int_en_q, halted;

  always #4 clk = ~clk;

  instr_cycle_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .acc_q(acc_q), .pc_q(pc_q), .int_en_q(int_en_q), .halted(halted)
  );

  // synchronous single-port memory model
  logic [DW-1:0] mem [MEMW];
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [AW+DW-1:0] exp_q[$];
  logic [AW+DW-1:0] item;
  int cyc = 0;
  int first_rd, halt_at, quiet_viol;
  logic [AW-1:0] pc_at_halt;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ins(input bit ind, input logic [2:0] op, input logic [11:0] a);
    return {ind, op, a};
  endfunction

  // monitor: pops the scoreboard on each write, records timing
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_rd && first_rd < 0) first_rd = cyc;
      if (halted && halt_at < 0) begin
        halt_at = cyc;
        pc_at_halt = pc_q;
      end
      if (halted && (mem_rd || mem_wr)) quiet_viol++;
      if (mem_wr) begin
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R6/R8 unexpected write act=%0h exp=none", {mem_addr, mem_wdata});
        end else begin
          item = exp_q.pop_front();
          if (item !== {mem_addr, mem_wdata}) begin
            n_fail++;
            $display("FAIL R6/R8 write act=%0h exp=%0h", {mem_addr, mem_wdata}, item);
          end
        end
      end
    end
  end

  task automatic begin_run(input logic irq);
    logic was_halted;
    @(negedge clk);
    was_halted = halted;
    rst_n = 1'b0;
    irq_req = irq;
    for (int i = 0; i < MEMW; i++) mem[i] = '0;
    exp_q.delete();
    first_rd = -1;
    halt_at = -1;
    quiet_viol = 0;
    #1;
    if (was_halted) check("R10 halt left on reset", {31'd0, halted}, 32'd0);
  endtask

  task automatic go();
    repeat (2) @(negedge clk);
    check("R1 reset pc", pc_q, 32'h010);
    check("R1 reset acc", acc_q, 32'h0);
    check("R1 reset int_en", {31'd0, int_en_q}, 32'd0);
    check("R1 reset strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
    check("R1 reset halted", {31'd0, halted}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 3000 && halt_at < 0; i++) @(negedge clk);
    check("R10 halted reached", {31'd0, halted}, 32'd1);
    repeat (20) @(negedge clk);
    check("R10 halt sticky", {31'd0, halted}, 32'd1);
    check("R10 no strobes after halt", quiet_viol, 32'd0);
    check("R10 pc frozen", pc_q, pc_at_halt);
    check("R6/R8 all writes seen", exp_q.size(), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    irq_req = 1'b0;

    // A: direct accumulate, request held but masked (R2 R3 R4 R9)
    begin_run(1'b1);
    mem['h10] = ins(0, 3'd0, 12'h080);
    mem['h11] = ins(0, 3'd7, 12'h000);
    mem['h80] = 16'h0005;
    go();
    check("R4 acc direct", acc_q, 32'h5);
    check("R2 R9 cycles first read to halted", halt_at - first_rd, 32'd10);
    check("R3 pc after halt fetch", pc_q, 32'h012);
    check("R9 int_en stays clear", {31'd0, int_en_q}, 32'd0);

    // B: indirect then direct accumulate with wrap (R5 R4)
    begin_run(1'b0);
    mem['h10] = ins(1, 3'd0, 12'h082);
    mem['h11] = ins(0, 3'd0, 12'h083);
    mem['h12] = ins(0, 3'd7, 12'h000);
    mem['h82] = 16'h0080;
    mem['h80] = 16'h1234;
    mem['h83] = 16'hF000;
    go();
    check("R5 R4 acc indirect with wrap", acc_q, 32'h0234);
    check("R5 cycles indirect", halt_at - first_rd, 32'd20);

    // C: bump-and-skip, nonzero result (R6)
    begin_run(1'b0);
    mem['h10] = ins(0, 3'd1, 12'h090);
    mem['h11] = ins(0, 3'd0, 12'h080);
    mem['h12] = ins(0, 3'd7, 12'h000);
    mem['h90] = 16'h0003;
    mem['h80] = 16'h0005;
    exp_q.push_back({12'h090, 16'h0004});
    go();
    check("R6 no skip acc", acc_q, 32'h5);
    check("R6 no skip pc", pc_q, 32'h013);

    // D: bump-and-skip, zero result skips (R6)
    begin_run(1'b0);
    mem['h10] = ins(0, 3'd1, 12'h090);
    mem['h11] = ins(0, 3'd0, 12'h080);
    mem['h12] = ins(0, 3'd0, 12'h081);
    mem['h13] = ins(0, 3'd7, 12'h000);
    mem['h90] = 16'hFFFF;
    mem['h80] = 16'h0005;
    mem['h81] = 16'h0007;
    exp_q.push_back({12'h090, 16'h0000});
    go();
    check("R6 skip acc", acc_q, 32'h7);
    check("R6 skip pc", pc_q, 32'h014);

    // E: enable interrupts, no request (R7 R2)
    begin_run(1'b0);
    mem['h10] = ins(0, 3'd2, 12'h000);
    mem['h11] = ins(0, 3'd7, 12'h000);
    go();
    check("R7 int_en set", {31'd0, int_en_q}, 32'd1);
    check("R7 R2 cycles", halt_at - first_rd, 32'd7);
    check("R3 acc untouched", acc_q, 32'h0);

    // F: interrupt taken after the following instruction (R7 R8)
    begin_run(1'b1);
    mem['h10] = ins(0, 3'd2, 12'h000);
    mem['h11] = ins(0, 3'd0, 12'h080);
    mem['h12] = ins(0, 3'd0, 12'h080);
    mem['h13] = ins(0, 3'd7, 12'h000);
    mem['h01] = ins(0, 3'd0, 12'h081);
    mem['h02] = ins(0, 3'd7, 12'h000);
    mem['h80] = 16'h0005;
    mem['h81] = 16'h0007;
    exp_q.push_back({12'h000, 16'h0012});
    go();
    check("R8 acc via handler", acc_q, 32'd12);
    check("R8 pc in handler", pc_q, 32'h003);
    check("R8 int_en cleared", {31'd0, int_en_q}, 32'd0);

    // reset out of halt once more (R10 R1)
    begin_run(1'b0);
    mem['h10] = ins(0, 3'd7, 12'h000);
    go();
    check("R3 halt only pc", pc_q, 32'h011);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule